// File: doc/BRIEF.md
# Buck Controller Start-Up and Shut-Down Sequencer

This block orders the power-up and power-down of a synchronous buck controller. It receives three digitized levels: the bias supply, the multi-function enable pin and the feedback node. From these it decides when the converter may run and which reference the converter regulates to. It also generates the digital reference ramp that the error comparator follows during start-up.

Supply qualification uses hysteresis. The enable pin has three meanings: shutdown, enabled with the internal reference, or enabled with the pin level itself as the regulation target. Once both supply and enable are good, a current-limit sample window opens first. Its length is set by a limit-setting code. When the window closes, the reference climbs one code per prescaled tick until it reaches the target, and a done flag is then raised for the protection logic.

Both gates are held off while an already charged output sits above the climbing reference. A shutdown or a protection fault starts a soft-stop that requests output discharge. A fault stays latched until the enable or the supply is cycled.

All levels share one code scale, with 40 codes per volt at the default parameters. The analog comparators, converters, drivers and discharge switch sit outside the block.

Top module: `startup_seq`

## Requirements
- R1: `vcc_good` rises one clock after `vcc_code` exceeds SUP_RISE and falls one clock after `vcc_code` drops below SUP_FALL. Between the two thresholds it keeps its value.
- R2: A pin code above EN_HI enables the converter with the internal reference. `ext_mode` is then 0 and the ramp target is INT_REF.
- R3: A pin code from EXT_MIN to EXT_MAX inclusive enables the converter in external-reference mode. `ext_mode` is then 1 and the ramp target equals the pin code.
- R4: A pin code below EN_LO is shutdown and starts a soft-stop. A pin code in either gap between the bands changes neither the enable state, the mode nor the target.
- R5: One clock after supply and enable are both good, `sample_win` goes high. It stays high for `lim_set`*WIN_UNIT+1 clocks, and `ref_code` stays 0 throughout.
- R6: After the window, `ref_code` moves one code toward the target every PRESC clocks and never changes by more than one code per clock.
- R7: `ss_done` rises one clock after `ref_code` equals the target. The ramp phase therefore lasts target*PRESC+1 clocks when starting from 0.
- R8: During the ramp, `gate_inhibit` is high while `ref_code` is below `fb_code`. Once the ramp has caught up, it stays low for the rest of that start.
- R9: `discharge_req` is high during the soft-stop. The soft-stop ends, with `discharge_req` low, one clock after `fb_code` is at or below STOP_LVL.
- R10: A `fault_req` pulse during the window, the ramp or regulation causes a soft-stop on the next clock. The fault is latched, and no restart happens until enable or supply goes away and returns.
- R11: If the converter is re-enabled during a soft-stop, it goes straight into a new sample window.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| vcc_code | input | CODE_W | digitized bias supply level |
| pin_code | input | CODE_W | digitized enable/reference pin level |
| fb_code | input | CODE_W | digitized feedback level |
| lim_set | input | LIM_W | current-limit setting product, scales the sample window |
| fault_req | input | 1 | soft-stop request from the protection logic |
| vcc_good | output | 1 | supply qualified |
| ext_mode | output | 1 | external reference selected |
| sample_win | output | 1 | current-limit sample window active |
| ref_code | output | CODE_W | digital soft-start reference |
| gate_inhibit | output | 1 | hold both gates off (pre-biased output) |
| ss_done | output | 1 | soft-start complete |
| discharge_req | output | 1 | soft-stop output discharge request |

## Verification
The bench builds the block with PRESC=4, WIN_UNIT=3 and INT_REF=50. With these values a full ramp to an external target of 132 finishes in a few hundred clocks. The exact window and ramp lengths can therefore be counted for several targets and limit settings, including a zero setting. The small prescaler also brings the pre-bias hold within reach: a feedback of 30 must produce exactly 120 inhibited clocks. The threshold parameters keep the voltage scale of the defaults, so the hysteresis and band-gap cases are checked on the same codes the defaults use.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_SAMPLE = 3'd1,
    ST_RAMP   = 3'd2,
    ST_DONE   = 3'd3,
    ST_STOP   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/supply_mon.sv
module supply_mon #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned RISE   = 164,
  parameter int unsigned FALL   = 156
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] vcc_code,
  output logic              good_q
);
  localparam logic [CODE_W-1:0] RISE_C = CODE_W'(RISE);
  localparam logic [CODE_W-1:0] FALL_C = CODE_W'(FALL);

  always_ff @(posedge clk) begin
    if (rst)                            good_q <= 1'b0;
    else if (!good_q && vcc_code > RISE_C) good_q <= 1'b1;
    else if (good_q && vcc_code < FALL_C)  good_q <= 1'b0;
  end

  // R1
  good_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(good_q) |-> $past(vcc_code) > RISE_C);
  // R1
  good_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(good_q) |-> $past(vcc_code) < FALL_C);
endmodule

// File: rtl/pin_decode.sv
module pin_decode #(
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned EN_HI   = 140,
  parameter int unsigned EN_LO   = 16,
  parameter int unsigned EXT_MIN = 20,
  parameter int unsigned EXT_MAX = 132,
  parameter int unsigned INT_REF = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] pin_code,
  output logic              en_q,
  output logic              ext_q,
  output logic [CODE_W-1:0] tgt_q
);
  localparam logic [CODE_W-1:0] HI_C   = CODE_W'(EN_HI);
  localparam logic [CODE_W-1:0] LO_C   = CODE_W'(EN_LO);
  localparam logic [CODE_W-1:0] XMIN_C = CODE_W'(EXT_MIN);
  localparam logic [CODE_W-1:0] XMAX_C = CODE_W'(EXT_MAX);
  localparam logic [CODE_W-1:0] IREF_C = CODE_W'(INT_REF);

  logic lvl_hi, lvl_ext, lvl_lo;

  always_comb begin
    lvl_hi  = pin_code > HI_C;
    lvl_ext = (pin_code >= XMIN_C) && (pin_code <= XMAX_C);
    lvl_lo  = pin_code < LO_C;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      ext_q <= 1'b0;
      tgt_q <= IREF_C;
    end else if (lvl_hi) begin
      en_q  <= 1'b1;
      ext_q <= 1'b0;
      tgt_q <= IREF_C;
    end else if (lvl_ext) begin
      en_q  <= 1'b1;
      ext_q <= 1'b1;
      tgt_q <= pin_code;
    end else if (lvl_lo) begin
      en_q  <= 1'b0;
    end
  end

  // R4
  en_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(en_q) |-> $past(pin_code) < LO_C);
  // R3
  ext_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_q) |-> tgt_q == $past(pin_code));
endmodule

// File: rtl/ramp_gen.sv
module ramp_gen #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned PRESC  = 1569
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  input  logic [CODE_W-1:0] tgt,
  output logic [CODE_W-1:0] ref_q
);
  localparam int unsigned PC_W = (PRESC > 1) ? $clog2(PRESC) : 1;

  logic tick;

  generate
    if (PRESC > 1) begin : g_div
      logic [PC_W-1:0] pc_q;
      always_ff @(posedge clk) begin
        if (rst || clr || !run)               pc_q <= '0;
        else if (pc_q == PC_W'(PRESC - 1))    pc_q <= '0;
        else                                  pc_q <= pc_q + 1'b1;
      end
      assign tick = run && (pc_q == PC_W'(PRESC - 1));
    end else begin : g_nodiv
      assign tick = run;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr)                  ref_q <= '0;
    else if (tick && ref_q < tgt)    ref_q <= ref_q + 1'b1;
    else if (tick && ref_q > tgt)    ref_q <= ref_q - 1'b1;
  end

  // R6
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !clr) |->
      (ref_q == $past(ref_q) || ref_q == $past(ref_q) + 1'b1 ||
       ref_q == $past(ref_q) - 1'b1));
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import sseq_pkg::*;
#(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned LIM_W    = 4,
  parameter int unsigned WIN_UNIT = 500,
  parameter int unsigned PRESC    = 1569,
  parameter int unsigned SUP_RISE = 164,
  parameter int unsigned SUP_FALL = 156,
  parameter int unsigned EN_HI    = 140,
  parameter int unsigned EN_LO    = 16,
  parameter int unsigned EXT_MIN  = 20,
  parameter int unsigned EXT_MAX  = 132,
  parameter int unsigned INT_REF  = 20,
  parameter int unsigned STOP_LVL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] vcc_code,
  input  logic [CODE_W-1:0] pin_code,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [LIM_W-1:0]  lim_set,
  input  logic              fault_req,
  output logic              vcc_good,
  output logic              ext_mode,
  output logic              sample_win,
  output logic [CODE_W-1:0] ref_code,
  output logic              gate_inhibit,
  output logic              ss_done,
  output logic              discharge_req
);
  localparam int unsigned WIN_W = LIM_W + $clog2(WIN_UNIT + 1);
  localparam logic [CODE_W-1:0] STOP_C = CODE_W'(STOP_LVL);

  seq_state_t       st_q;
  logic [WIN_W-1:0] win_q, win_len;
  logic             en_q, flt_q, caught_q, run, active, ramp_on;
  logic [CODE_W-1:0] tgt;

  supply_mon #(.CODE_W(CODE_W), .RISE(SUP_RISE), .FALL(SUP_FALL)) u_sup (
    .clk(clk), .rst(rst), .vcc_code(vcc_code), .good_q(vcc_good));

  pin_decode #(.CODE_W(CODE_W), .EN_HI(EN_HI), .EN_LO(EN_LO),
               .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX), .INT_REF(INT_REF)) u_pin (
    .clk(clk), .rst(rst), .pin_code(pin_code),
    .en_q(en_q), .ext_q(ext_mode), .tgt_q(tgt));

  always_comb begin
    run     = en_q && vcc_good;
    active  = (st_q == ST_SAMPLE) || (st_q == ST_RAMP) || (st_q == ST_DONE);
    ramp_on = (st_q == ST_RAMP) || (st_q == ST_DONE);
    win_len = WIN_W'(lim_set) * WIN_W'(WIN_UNIT);
  end

  ramp_gen #(.CODE_W(CODE_W), .PRESC(PRESC)) u_ramp (
    .clk(clk), .rst(rst), .clr(!ramp_on), .run(ramp_on),
    .tgt(tgt), .ref_q(ref_code));

  always_ff @(posedge clk) begin
    if (rst)                        flt_q <= 1'b0;
    else if (!run)                  flt_q <= 1'b0;
    else if (fault_req && active)   flt_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_OFF;
      win_q    <= '0;
      caught_q <= 1'b0;
    end else begin
      case (st_q)
        ST_OFF: if (run && !flt_q) begin
          st_q  <= ST_SAMPLE;
          win_q <= win_len;
        end
        ST_SAMPLE: begin
          caught_q <= 1'b0;
          if (!run || fault_req)   st_q <= ST_STOP;
          else if (win_q == '0)    st_q <= ST_RAMP;
          else                     win_q <= win_q - 1'b1;
        end
        ST_RAMP: begin
          if (ref_code >= fb_code) caught_q <= 1'b1;
          if (!run || fault_req)   st_q <= ST_STOP;
          else if (ref_code == tgt) st_q <= ST_DONE;
        end
        ST_DONE: if (!run || fault_req) st_q <= ST_STOP;
        ST_STOP: begin
          if (run && !flt_q) begin
            st_q  <= ST_SAMPLE;
            win_q <= win_len;
          end else if (fb_code <= STOP_C) begin
            st_q  <= ST_OFF;
          end
        end
        default: st_q <= ST_OFF;
      endcase
    end
  end

  always_comb begin
    sample_win    = (st_q == ST_SAMPLE);
    ss_done       = (st_q == ST_DONE);
    discharge_req = (st_q == ST_STOP);
    gate_inhibit  = (st_q == ST_RAMP) && !caught_q && (ref_code < fb_code);
  end

  // R5
  win_ref_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sample_win |-> ref_code == '0);
  // R7
  done_at_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_done) |-> $past(ref_code) == $past(tgt));
  // R10
  fault_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_req && active) |=> discharge_req);
  // R9
  stop_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(discharge_req) && !sample_win) |-> $past(fb_code) <= STOP_C);
endmodule

// File: tb/sim_startup_seq.sv
module sim_startup_seq;
  localparam int PRESC = 4;
  localparam int UNIT  = 3;
  localparam int IREF  = 50;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] vcc_code, pin_code, fb_code;
  logic [3:0] lim_set;
  logic       fault_req;
  logic       vcc_good, ext_mode, sample_win, gate_inhibit, ss_done, discharge_req;
  logic [7:0] ref_code;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  startup_seq #(.CODE_W(8), .LIM_W(4), .WIN_UNIT(UNIT), .PRESC(PRESC),
                .INT_REF(IREF)) u0 (
    .clk(clk), .rst(rst), .vcc_code(vcc_code), .pin_code(pin_code),
    .fb_code(fb_code), .lim_set(lim_set), .fault_req(fault_req),
    .vcc_good(vcc_good), .ext_mode(ext_mode), .sample_win(sample_win),
    .ref_code(ref_code), .gate_inhibit(gate_inhibit), .ss_done(ss_done),
    .discharge_req(discharge_req));

  // pin code, limit setting, expected ext_mode, expected target
  localparam int NV = 4;
  localparam int V_PIN [NV] = '{200, 100, 60, 132};
  localparam int V_LIM [NV] = '{2, 0, 5, 1};
  localparam int V_EXT [NV] = '{0, 1, 1, 1};
  localparam int V_TGT [NV] = '{IREF, 100, 60, 132};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_win(output int wlen);
    int k = 0;
    while (!sample_win && k < 20) begin k++; tick(1); end
    wlen = 0;
    while (sample_win && wlen < 200) begin wlen++; tick(1); end
  endtask

  task automatic wait_done(output int rlen, output int inh);
    rlen = 0;
    inh = 0;
    while (!ss_done && rlen < 3000) begin
      if (gate_inhibit) inh++;
      rlen++;
      tick(1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int wl, rl, ih;
    rst = 1'b1; vcc_code = 0; pin_code = 0; fb_code = 0; lim_set = 0; fault_req = 0;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R12
    chk("R12 outs", {vcc_good, ext_mode, sample_win, gate_inhibit, ss_done,
                     discharge_req, ref_code}, 0);

    // R1 hysteresis
    vcc_code = 170; tick(2); chk("R1 rise", vcc_good, 1);
    vcc_code = 160; tick(2); chk("R1 hold high", vcc_good, 1);
    vcc_code = 150; tick(2); chk("R1 fall", vcc_good, 0);
    vcc_code = 160; tick(2); chk("R1 hold low", vcc_good, 0);
    vcc_code = 170; tick(2); chk("R1 rise again", vcc_good, 1);

    // table: R2 R3 R5 R7
    for (int i = 0; i < NV; i++) begin
      pin_code = 0; fb_code = 0; tick(6);
      lim_set = 4'(V_LIM[i]); pin_code = 8'(V_PIN[i]);
      wait_win(wl);
      chk("R5 window length", wl, V_LIM[i] * UNIT + 1);
      wait_done(rl, ih);
      chk("R7 ramp length", rl, V_TGT[i] * PRESC + 1);
      chk("R3 R2 final ref", ref_code, V_TGT[i]);
      chk("R2 R3 ext_mode", ext_mode, V_EXT[i]);
    end

    // R4 dead bands then shutdown; R9 discharge
    pin_code = 200; tick(3);
    chk("R2 back to internal", ext_mode, 0);
    pin_code = 135; tick(3);
    chk("R4 upper gap mode", ext_mode, 0);
    chk("R4 upper gap running", ss_done, 1);
    pin_code = 18; tick(3);
    chk("R4 lower gap running", ss_done, 1);
    fb_code = 40; pin_code = 10; tick(3);
    chk("R4 shutdown soft-stop", discharge_req, 1);
    tick(20);
    chk("R9 discharge held", discharge_req, 1);
    fb_code = 1; tick(2);
    chk("R9 discharge ends", discharge_req, 0);

    // R8 pre-bias
    fb_code = 30; lim_set = 0; pin_code = 200;
    wait_win(wl);
    wait_done(rl, ih);
    chk("R8 inhibit cycles", ih, 30 * PRESC);
    chk("R8 final ref", ref_code, IREF);

    // R10 latched fault
    fb_code = 0;
    fault_req = 1; tick(1); fault_req = 0;
    chk("R10 stop after fault", discharge_req, 1);
    tick(10);
    chk("R10 no restart", {sample_win, ss_done, discharge_req}, 0);
    pin_code = 0; tick(3); lim_set = 5; pin_code = 200; tick(3);
    chk("R10 restart after cycling", sample_win, 1);

    // R11 re-enable during soft-stop
    wait_done(rl, ih);
    fb_code = 40; pin_code = 0; tick(4);
    chk("R11 in soft-stop", discharge_req, 1);
    pin_code = 200; tick(3);
    chk("R11 direct window", sample_win, 1);
    chk("R11 discharge off", discharge_req, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule